// File: doc/BRIEF.md
# Page-Mode Asynchronous Static RAM Controller

This block connects a simple request/response host port to an external asynchronous static RAM. The RAM has no clock, so the controller times every access by counting cycles of its own clock. It drives the full address in one step, a data bus split into output value, output enable and input value, and three active-low strobes: chip select, write strobe and read-drive strobe. The number of wait cycles comes from access times given in picoseconds, each divided by the clock period and rounded up.

After a read, the controller keeps the RAM selected and remembers which page was read. A page is the group of words that share the same upper address bits. If the next read stays in that page and arrives soon enough, it uses the shorter in-page access time. In every other case it uses the full random-access time. Any write, a release of chip select after a quiet period, or a reset closes the page.

Top module: `pgsram_ctrl`

## Requirements
- R1: During reset and right after it, chip select, write strobe and read-drive strobe are high (inactive), the data bus is not driven, `host_ready` is low and `host_rdata` is zero.
- R2: A read that starts with no open page holds its address for ACC_CYC = ceil(T_ACC_PS / CLK_PS) cycles (9 by default) before the data is sampled. `host_ready` rises ACC_CYC cycles after the request is accepted and carries the RAM word.
- R3: A read whose upper address bits (above the log2(PAGE_WORDS) offset bits, so bits 10:8 by default) match those of the read just completed, while that page is still open, completes in PAGE_CYC = ceil(T_PAGE_PS / CLK_PS) cycles (4 by default). This includes a read of the very same address.
- R4: A read to a different page uses the full ACC_CYC count, even while a page is open.
- R5: A write drives the data bus one cycle before the write strobe falls. It holds the write strobe low for exactly ACC_CYC cycles with the address stable, and keeps the data driven for one more cycle after the strobe rises. It completes ACC_CYC+2 cycles after acceptance from the idle state, and the RAM then holds the written word.
- R6: A write that follows a read while the page is open first spends one turnaround cycle with the read-drive strobe high and the bus undriven. It completes ACC_CYC+3 cycles after acceptance.
- R7: The data bus is never driven while the read-drive strobe is low.
- R8: After any write, the next read takes the full ACC_CYC count.
- R9: After HOLD_CYC cycles (4 by default) following a completed read with no new request, chip select is released and the page closes. A request sampled within those HOLD_CYC cycles still finds the page open.
- R10: Each accepted request produces exactly one `host_ready` pulse, one cycle wide.
- R11: The read-drive strobe and the write strobe are never low together, and neither is low without chip select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_req | input | 1 | Access request, sampled when the controller is idle or holding a page |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Word address |
| host_wdata | input | DATA_W | Write data |
| host_ready | output | 1 | One-cycle completion pulse |
| host_rdata | output | DATA_W | Read data, valid with `host_ready` on reads |
| mem_addr | output | ADDR_W | RAM address bus |
| mem_dq_o | output | DATA_W | Value driven onto the RAM data bus |
| mem_dq_oe | output | 1 | Data bus drive enable |
| mem_dq_i | input | DATA_W | Value read from the RAM data bus |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Read-drive strobe, active low |

## Verification
The RAM model returns the inverted word until the address has been stable for the required count. A read that is sampled early therefore shows up both as wrong data and as a wrong latency. Reads are tried from idle, inside the open page (at the same address, at a different offset, and at the last cycle before the page times out), across pages, and one cycle past the timeout. These cases separate a page hit, a page miss and a closed page. Writes are issued both from idle and straight after a read, which tells the plain write timing apart from the extra turnaround cycle. Read-back of the written words confirms that each write was stored and that a write closes the page.

// File: rtl/pgsram_pkg.sv
package pgsram_pkg;

  typedef enum logic [2:0] {
    S_IDLE     = 3'd0,
    S_RD_WAIT  = 3'd1,
    S_RD_OPEN  = 3'd2,
    S_TURN     = 3'd3,
    S_WR_SETUP = 3'd4,
    S_WR_PULSE = 3'd5,
    S_WR_HOLD  = 3'd6
  } pg_state_e;

  // Whole clock cycles that cover a time in picoseconds (rounded up).
  function automatic int unsigned cyc_ceil(input int unsigned t_ps,
                                           input int unsigned clk_ps);
    return (t_ps + clk_ps - 1) / clk_ps;
  endfunction

endpackage

// File: rtl/pgsram_rst_sync.sv
module pgsram_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q  <= 1'b0;
      rst_s_n <= 1'b0;
    end else begin
      meta_q  <= 1'b1;
      rst_s_n <= meta_q;
    end
  end
endmodule

// File: rtl/pgsram_wait_cnt.sv
module pgsram_wait_cnt #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             dec,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)     cnt_d = load_val;
    else if (dec) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt_q <= '0;
    else if (load || dec) cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);

  // R2: a wait is never stepped past zero (no wrap into a long wait)
  p_dec_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dec |-> !zero);
endmodule

// File: rtl/pgsram_page_track.sv
module pgsram_page_track #(
  parameter int PG_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set,
  input  logic            clr,
  input  logic [PG_W-1:0] set_page,
  input  logic [PG_W-1:0] look_page,
  output logic            hit
);
  logic            valid_q, valid_d;
  logic [PG_W-1:0] page_q;

  always_comb begin
    valid_d = valid_q;
    if (clr)      valid_d = 1'b0;
    else if (set) valid_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   page_q <= '0;
    else if (set) page_q <= set_page;
  end

  assign hit = valid_q && (look_page == page_q);

  // R8: a page closed by a write or by a chip-select release stays closed
  p_closed_no_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> !hit);
endmodule

// File: rtl/pgsram_ctrl.sv
module pgsram_ctrl
  import pgsram_pkg::*;
#(
  parameter int ADDR_W     = 11,
  parameter int DATA_W     = 8,
  parameter int PAGE_WORDS = 256,
  parameter int CLK_PS     = 8000,
  parameter int T_ACC_PS   = 70000,
  parameter int T_PAGE_PS  = 30000,
  parameter int HOLD_CYC   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_req,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic              host_ready,
  output logic [DATA_W-1:0] host_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n
);
  localparam int ACC_RAW  = int'(cyc_ceil(T_ACC_PS, CLK_PS));
  localparam int PAGE_RAW = int'(cyc_ceil(T_PAGE_PS, CLK_PS));
  localparam int ACC_CYC  = (ACC_RAW  < 1) ? 1 : ACC_RAW;
  localparam int PAGE_CYC = (PAGE_RAW < 1) ? 1 : PAGE_RAW;
  localparam int HOLD_EFF = (HOLD_CYC < 1) ? 1 : HOLD_CYC;
  localparam int MAX_AP   = (ACC_CYC > PAGE_CYC) ? ACC_CYC : PAGE_CYC;
  localparam int WAIT_MAX = (MAX_AP > HOLD_EFF) ? MAX_AP : HOLD_EFF;
  localparam int CNT_W    = $clog2(WAIT_MAX + 1);
  localparam int OFS_W    = $clog2(PAGE_WORDS);
  localparam int PG_W     = ADDR_W - OFS_W;

  localparam logic [CNT_W-1:0] LD_ACC  = CNT_W'(ACC_CYC - 1);
  localparam logic [CNT_W-1:0] LD_PAGE = CNT_W'(PAGE_CYC - 1);
  localparam logic [CNT_W-1:0] LD_HOLD = CNT_W'(HOLD_EFF - 1);

  logic rst_s_n;

  pgsram_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_s_n (rst_s_n)
  );

  pg_state_e st_q, st_d;
  logic [ADDR_W-1:0] addr_d;
  logic              ce_d, oe_d, we_d, dqoe_d, rdy_d;
  logic              wd_ld, rd_cap;
  logic              cnt_ld, cnt_dec, cnt_zero;
  logic [CNT_W-1:0]  cnt_val;
  logic              pg_set, pg_clr, pg_hit;

  pgsram_wait_cnt #(.CNT_W(CNT_W)) u_wait (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .load     (cnt_ld),
    .dec      (cnt_dec),
    .load_val (cnt_val),
    .zero     (cnt_zero)
  );

  pgsram_page_track #(.PG_W(PG_W)) u_page (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .set       (pg_set),
    .clr       (pg_clr),
    .set_page  (mem_addr[ADDR_W-1:OFS_W]),
    .look_page (host_addr[ADDR_W-1:OFS_W]),
    .hit       (pg_hit)
  );

  // Next-state and next-output logic
  always_comb begin
    st_d    = st_q;
    addr_d  = mem_addr;
    ce_d    = mem_ce_n;
    oe_d    = mem_oe_n;
    we_d    = mem_we_n;
    dqoe_d  = mem_dq_oe;
    rdy_d   = 1'b0;
    wd_ld   = 1'b0;
    rd_cap  = 1'b0;
    cnt_ld  = 1'b0;
    cnt_dec = 1'b0;
    cnt_val = LD_ACC;
    pg_set  = 1'b0;
    pg_clr  = 1'b0;
    unique case (st_q)
      S_IDLE: begin
        if (host_req) begin
          addr_d = host_addr;
          ce_d   = 1'b0;
          if (host_we) begin
            wd_ld  = 1'b1;
            dqoe_d = 1'b1;
            pg_clr = 1'b1;
            st_d   = S_WR_SETUP;
          end else begin
            oe_d   = 1'b0;
            cnt_ld = 1'b1;
            st_d   = S_RD_WAIT;
          end
        end
      end
      S_RD_WAIT: begin
        if (cnt_zero) begin
          rd_cap  = 1'b1;
          rdy_d   = 1'b1;
          pg_set  = 1'b1;
          cnt_ld  = 1'b1;
          cnt_val = LD_HOLD;
          st_d    = S_RD_OPEN;
        end else begin
          cnt_dec = 1'b1;
        end
      end
      S_RD_OPEN: begin
        if (host_req) begin
          addr_d = host_addr;
          if (host_we) begin
            oe_d   = 1'b1;
            wd_ld  = 1'b1;
            pg_clr = 1'b1;
            st_d   = S_TURN;
          end else begin
            cnt_ld  = 1'b1;
            cnt_val = pg_hit ? LD_PAGE : LD_ACC;
            st_d    = S_RD_WAIT;
          end
        end else if (cnt_zero) begin
          ce_d   = 1'b1;
          oe_d   = 1'b1;
          pg_clr = 1'b1;
          st_d   = S_IDLE;
        end else begin
          cnt_dec = 1'b1;
        end
      end
      S_TURN: begin
        dqoe_d = 1'b1;
        st_d   = S_WR_SETUP;
      end
      S_WR_SETUP: begin
        we_d   = 1'b0;
        cnt_ld = 1'b1;
        st_d   = S_WR_PULSE;
      end
      S_WR_PULSE: begin
        if (cnt_zero) begin
          we_d = 1'b1;
          st_d = S_WR_HOLD;
        end else begin
          cnt_dec = 1'b1;
        end
      end
      S_WR_HOLD: begin
        dqoe_d = 1'b0;
        ce_d   = 1'b1;
        rdy_d  = 1'b1;
        st_d   = S_IDLE;
      end
      default: st_d = S_IDLE;
    endcase
  end

  // State and strobe registers
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      st_q       <= S_IDLE;
      mem_addr   <= '0;
      mem_ce_n   <= 1'b1;
      mem_oe_n   <= 1'b1;
      mem_we_n   <= 1'b1;
      mem_dq_oe  <= 1'b0;
      host_ready <= 1'b0;
    end else begin
      st_q       <= st_d;
      mem_addr   <= addr_d;
      mem_ce_n   <= ce_d;
      mem_oe_n   <= oe_d;
      mem_we_n   <= we_d;
      mem_dq_oe  <= dqoe_d;
      host_ready <= rdy_d;
    end
  end

  // Data registers with explicit load enables
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n)   mem_dq_o <= '0;
    else if (wd_ld) mem_dq_o <= host_wdata;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n)    host_rdata <= '0;
    else if (rd_cap) host_rdata <= mem_dq_i;
  end

  // Bus protocol properties
  p_no_drive_oe_r7: assert property (@(posedge clk) disable iff (!rst_s_n)
    !mem_oe_n |-> !mem_dq_oe);

  p_we_oe_excl_r11: assert property (@(posedge clk) disable iff (!rst_s_n)
    !mem_we_n |-> mem_oe_n);

  p_strobe_ce_r11: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!mem_oe_n || !mem_we_n) |-> !mem_ce_n);

  p_ready_pulse_r10: assert property (@(posedge clk) disable iff (!rst_s_n)
    host_ready |=> !host_ready);

  p_we_addr_hold_r5: assert property (@(posedge clk) disable iff (!rst_s_n)
    !mem_we_n |=> (mem_we_n || $stable(mem_addr)));

  p_we_rise_data_r5: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(mem_we_n) |-> (mem_dq_oe && !mem_ce_n));

  p_turn_idle_r6: assert property (@(posedge clk) disable iff (!rst_s_n)
    ($rose(mem_oe_n) && !mem_ce_n) |-> !mem_dq_oe);
endmodule

// File: tb/pgsram_ctrl_bench.sv
`timescale 1ns/1ps
module pgsram_ctrl_bench;
  localparam int ADDR_W = 11;
  localparam int DATA_W = 8;
  localparam int OFS    = 8;
  localparam int CLKPS  = 8000;
  localparam int ACC    = (70000 + CLKPS - 1) / CLKPS;
  localparam int PAGE   = (30000 + CLKPS - 1) / CLKPS;
  localparam int HOLD   = 4;
  localparam int WORDS  = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              host_req, host_we;
  logic [ADDR_W-1:0] host_addr;
  logic [DATA_W-1:0] host_wdata;
  logic              host_ready;
  logic [DATA_W-1:0] host_rdata;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_dq_o, mem_dq_i;
  logic              mem_dq_oe, mem_ce_n, mem_we_n, mem_oe_n;

  always #4 clk = ~clk;

  pgsram_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_WORDS(256), .CLK_PS(CLKPS),
    .T_ACC_PS(70000), .T_PAGE_PS(30000), .HOLD_CYC(HOLD)
  ) u_pgsram_ctrl (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_ready(host_ready),
    .host_rdata(host_rdata), .mem_addr(mem_addr), .mem_dq_o(mem_dq_o),
    .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i), .mem_ce_n(mem_ce_n),
    .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n)
  );

  int checks = 0;
  int errors = 0;
  int txn    = 0;
  int pulses = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  // Behavioural RAM with access-time checker
  logic [DATA_W-1:0] ram [0:WORDS-1];
  int                sc = 0, reqd = ACC, wl = 0;
  bit                pg_open = 1'b0;
  logic [ADDR_W-1:0] prev_addr = '0;
  logic              prev_ce_n = 1'b1, prev_we_n = 1'b1;

  assign mem_dq_i = (!mem_ce_n && !mem_oe_n && sc >= reqd) ? ram[mem_addr] : ~ram[mem_addr];

  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_ce_n) begin
        sc = 0;
        pg_open = 1'b0;
      end else if (prev_ce_n || mem_addr != prev_addr) begin
        reqd = (!prev_ce_n && pg_open && (mem_addr >> OFS) == (prev_addr >> OFS)) ? PAGE : ACC;
        sc = 1;
      end else begin
        sc++;
      end
      if (!mem_oe_n && mem_dq_oe) chk(1'b0, "R7 bus driven during read", 1, 0);
      if (!mem_oe_n && !mem_we_n) chk(1'b0, "R11 both strobes low", 1, 0);
      if ((!mem_oe_n || !mem_we_n) && mem_ce_n) chk(1'b0, "R11 strobe without select", 1, 0);
      if (!mem_we_n) begin
        pg_open = 1'b0;
        if (prev_we_n) wl = 0;
        else if (mem_addr != prev_addr) chk(1'b0, "R5 address moved under write", 32'(mem_addr), 32'(prev_addr));
        wl++;
        if (!mem_dq_oe) chk(1'b0, "R5 data not driven in write", 0, 1);
      end else if (!prev_we_n) begin
        chk(wl == ACC, "R5 write strobe width", wl, ACC);
        chk(mem_dq_oe == 1'b1, "R5 data held after strobe", 32'(mem_dq_oe), 1);
        ram[mem_addr] = mem_dq_o;
      end
      if (host_ready) pulses++;
      if (host_ready && u_pulse_prev) chk(1'b0, "R10 ready wider than one cycle", 2, 1);
    end
    u_pulse_prev = host_ready;
    prev_addr = mem_addr;
    prev_ce_n = mem_ce_n;
    prev_we_n = mem_we_n;
  end
  logic u_pulse_prev = 1'b0;

  // Host-side expectation model
  bit last_rd = 1'b0;
  int last_a  = 0;

  task automatic do_acc(input bit w, input int a, input int d, input int gap,
                        input string tlat, input string tdat);
    int  exp_lat, n;
    bit  open;
    logic [DATA_W-1:0] exp_d;
    repeat (gap) @(negedge clk);
    open = last_rd && (gap < HOLD);
    if (w) exp_lat = open ? ACC + 3 : ACC + 2;
    else   exp_lat = (open && (a >> OFS) == (last_a >> OFS)) ? PAGE : ACC;
    exp_d = ram[a];
    host_req   = 1'b1;
    host_we    = w;
    host_addr  = ADDR_W'(a);
    host_wdata = DATA_W'(d);
    n = 0;
    do begin
      @(posedge clk);
      n++;
      @(negedge clk);
    end while (!host_ready && n < 200);
    host_req = 1'b0;
    txn++;
    chk(n - 1 == exp_lat, tlat, n - 1, exp_lat);
    if (w) begin
      chk(ram[a] == DATA_W'(d), tdat, 32'(ram[a]), d);
    end else begin
      chk(host_rdata == exp_d, tdat, 32'(host_rdata), 32'(exp_d));
      pg_open = 1'b1;
    end
    last_rd = !w;
    last_a  = a;
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      chk(1'b0, "watchdog expired", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < WORDS; i++) ram[i] = DATA_W'(i * 7 + 3);
    rst_n = 1'b0;
    host_req = 1'b0; host_we = 1'b0; host_addr = '0; host_wdata = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(mem_ce_n && mem_oe_n && mem_we_n, "R1 strobes idle in reset", 32'({mem_ce_n, mem_oe_n, mem_we_n}), 7);
    chk(!mem_dq_oe && !host_ready, "R1 bus and ready idle in reset", 32'({mem_dq_oe, host_ready}), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe && host_rdata == '0,
        "R1 idle after reset", 32'({mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe}), 14);

    do_acc(1'b0, 'h123, 0,    2, "R2 random read latency", "R2 random read data");
    do_acc(1'b0, 'h145, 0,    0, "R3 page hit latency",    "R3 page hit data");
    do_acc(1'b0, 'h1FF, 0,    3, "R3 hit at last open cycle (R9)", "R3 late hit data");
    do_acc(1'b0, 'h3FF, 0,    0, "R4 page miss latency",   "R4 page miss data");
    do_acc(1'b1, 'h3AA, 'h5C, 0, "R6 write after read latency", "R5 write stored");
    do_acc(1'b0, 'h3AA, 0,    0, "R8 read after write latency", "R5 read back written word");
    do_acc(1'b0, 'h3AB, 0,    4, "R9 read after timeout latency", "R9 read data");
    do_acc(1'b1, 'h010, 'hE1, 6, "R5 write from idle latency", "R5 write stored");
    do_acc(1'b1, 'h011, 'h1E, 0, "R5 second write latency", "R5 second write stored");
    do_acc(1'b0, 'h010, 0,    0, "R8 read after write latency", "R5 read back first word");
    do_acc(1'b0, 'h011, 0,    1, "R3 page hit latency",    "R5 read back second word");
    do_acc(1'b0, 'h7FF, 0,    0, "R4 top page miss latency", "R4 top page data");
    do_acc(1'b0, 'h700, 0,    2, "R3 hit to page start",   "R3 page start data");
    do_acc(1'b0, 'h7FF, 0,    0, "R3 hit on revisit",      "R3 revisit data");

    repeat (HOLD + 3) @(negedge clk);
    chk(mem_ce_n == 1'b1, "R9 select released after quiet period", 32'(mem_ce_n), 1);
    chk(pulses == txn, "R10 one ready per request", pulses, txn);
    finished = 1'b1;
    summary();
    $finish;
  end
endmodule